// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block gathers every interrupt source of a hardwired network controller into one 8-bit status register that the host reads over a simple synchronous register bus. Three single-cycle event strobes set sticky status bits: a duplicate-address detection on the local IP, a returned destination-unreachable report for a UDP send, and the PPPoE session going down. The host clears each of these bits by writing a one to it. The lower four status bits are not stored events. Each one summarises a per-socket interrupt register that lives elsewhere, and it follows that register: it stays set while the socket register is non-zero and drops once the socket register has been cleared.

A host-written enable mask selects which status bits can pull the active-low interrupt pin. The pin is registered and stays asserted for as long as any enabled bit is set. On every destination-unreachable strobe the block also stores the IP address and UDP port that were reported, so the host can find out which peer failed.

Bus reads are combinational: the read data belongs to the address presented in the same cycle. Writes take effect at the clock edge.

Top module: `nic_irq_aggregator`

## Requirements
- R1: After synchronous reset the status register (address 0x15), the enable mask (address 0x16), the captured address and the captured port read 0x00, and irq_n is 1.
- R2: A one-cycle strobe sets a status bit that is visible from the next cycle: ev_addr_clash sets bit 7, ev_unreach sets bit 6, ev_pppoe_down sets bit 5. The bit stays set until the host clears it.
- R3: A host write to address 0x15 clears each of bits 7..5 whose write-data bit is 1. A write-data bit of 0 leaves the status bit unchanged.
- R4: If a strobe and a write-one-to-clear hit the same bit in the same cycle, the bit ends up as 1.
- R5: Status bit n (n = 0..3) is 1 one cycle after socket n's 8-bit field of sock_ir_in (bits 8n+7..8n) is non-zero. It returns to 0 one cycle after that field is 0x00. Host writes to bits 3..0 have no effect.
- R6: On every ev_unreach strobe, including one that arrives while bit 6 is already set, the block stores uip_in and uport_in. The stored values read back at 0x17..0x1A (address, most significant byte first) and at 0x1B..0x1C (port, high byte first), and they hold when no strobe comes.
- R7: irq_n is registered. It is 0 exactly when (status AND mask) was non-zero in the previous cycle, so it follows a status or mask change one cycle later.
- R8: Status bit 4 always reads 0, even after a host write of 1 to it.
- R9: The enable mask at address 0x16 is read/write and keeps its value until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| ev_addr_clash | input | 1 | Strobe: another station claims the local IP |
| ev_unreach | input | 1 | Strobe: destination-unreachable report received |
| ev_pppoe_down | input | 1 | Strobe: PPPoE session closed |
| uip_in | input | IP_W (32) | Unreachable IP address reported with ev_unreach |
| uport_in | input | PORT_W (16) | Unreachable UDP port reported with ev_unreach |
| sock_ir_in | input | NSOCK*SIR_W (32) | Per-socket interrupt registers, socket n in bits 8n+7..8n |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The status register is tried with each event strobe alone, with a strobe and a clearing write in the same cycle, and with clearing writes that carry zeros, unrelated ones and the right ones. This separates sticky set from write-one-to-clear and shows which of the two wins. The socket summary bits are driven with one socket busy, then two, then back to idle, and written with ones, which shows that they follow their source and ignore the host. The interrupt pin is checked with the mask all open, with the mask closed and with a single-bit mask, in the cycle of each change and in the cycle after it. This confirms both the one-cycle delay and that masked sources stay silent. Two unreachable events are sent back to back, followed by a change of the inputs with no strobe, to show that the capture registers keep the most recent report.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int REG_W       = 8;
  localparam int STATUS_ADDR = 'h15;
  localparam int MASK_ADDR   = 'h16;
  localparam int UIP_ADDR    = 'h17;
  localparam int UPORT_ADDR  = 'h1B;
  localparam int BIT_CLASH   = 7;
  localparam int BIT_UNREACH = 6;
  localparam int BIT_PPPOE   = 5;
  localparam int BIT_RSVD    = 4;
  localparam int SOCK_SLOTS  = 4;
  localparam int NUM_EVENTS  = 3;
endpackage

// File: rtl/nic_irq_evbits.sv
module nic_irq_evbits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q[g] <= 1'b0;
      else if (set_i[g])
        q[g] <= 1'b1;          // a strobe beats a clear in the same cycle
      else if (clr_i[g])
        q[g] <= 1'b0;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/nic_irq_socksum.sv
module nic_irq_socksum #(
  parameter int NSOCK = 4,
  parameter int SIR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSOCK*SIR_W-1:0] sock_ir_i,
  output logic [NSOCK-1:0]       sum_o
);
  logic [NSOCK-1:0] sum_q;

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    always_ff @(posedge clk) begin
      if (rst)
        sum_q[s] <= 1'b0;
      else
        sum_q[s] <= |sock_ir_i[s*SIR_W +: SIR_W];
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/nic_irq_capture.sv
module nic_irq_capture #(
  parameter int IP_W   = 32,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [IP_W-1:0]   ip_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [IP_W-1:0]   ip_o,
  output logic [PORT_W-1:0] port_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ip_o   <= '0;
      port_o <= '0;
    end else if (cap_i) begin
      ip_o   <= ip_i;
      port_o <= port_i;
    end
  end
endmodule

// File: rtl/nic_irq_pin.sv
module nic_irq_pin #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_n_o
);
  always_ff @(posedge clk) begin
    if (rst)
      irq_n_o <= 1'b1;
    else
      irq_n_o <= ~(|(status_i & mask_i));
  end
endmodule

// File: rtl/nic_irq_aggregator.sv
module nic_irq_aggregator
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NSOCK  = 4,
  parameter int SIR_W  = 8,
  parameter int IP_W   = 32,
  parameter int PORT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [REG_W-1:0]       bus_wdata,
  output logic [REG_W-1:0]       bus_rdata,
  input  logic                   ev_addr_clash,
  input  logic                   ev_unreach,
  input  logic                   ev_pppoe_down,
  input  logic [IP_W-1:0]        uip_in,
  input  logic [PORT_W-1:0]      uport_in,
  input  logic [NSOCK*SIR_W-1:0] sock_ir_in,
  output logic                   irq_n
);
  localparam int IP_BYTES   = IP_W / REG_W;
  localparam int PORT_BYTES = PORT_W / REG_W;

  logic                  hit_status, hit_mask;
  logic [NUM_EVENTS-1:0] ev_set, ev_clr, ev_q;
  logic [NSOCK-1:0]      sock_sum;
  logic [SOCK_SLOTS-1:0] sock_field;
  logic [REG_W-1:0]      status_q;
  logic [REG_W-1:0]      mask_q;
  logic [IP_W-1:0]       uip_q;
  logic [PORT_W-1:0]     uport_q;

  assign hit_status = bus_we && (bus_addr == ADDR_W'(STATUS_ADDR));
  assign hit_mask   = bus_we && (bus_addr == ADDR_W'(MASK_ADDR));

  // event vector order: [2] address clash, [1] unreachable, [0] session down
  assign ev_set = {ev_addr_clash, ev_unreach, ev_pppoe_down};
  assign ev_clr = hit_status ? bus_wdata[BIT_CLASH:BIT_PPPOE] : '0;

  nic_irq_evbits #(.N(NUM_EVENTS)) u_ev (
    .clk(clk), .rst(rst), .set_i(ev_set), .clr_i(ev_clr), .q_o(ev_q)
  );

  nic_irq_socksum #(.NSOCK(NSOCK), .SIR_W(SIR_W)) u_sock (
    .clk(clk), .rst(rst), .sock_ir_i(sock_ir_in), .sum_o(sock_sum)
  );

  nic_irq_capture #(.IP_W(IP_W), .PORT_W(PORT_W)) u_cap (
    .clk(clk), .rst(rst), .cap_i(ev_unreach), .ip_i(uip_in),
    .port_i(uport_in), .ip_o(uip_q), .port_o(uport_q)
  );

  assign sock_field = SOCK_SLOTS'(sock_sum);
  assign status_q   = {ev_q, 1'b0, sock_field};

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (hit_mask)
      mask_q <= bus_wdata;
  end

  nic_irq_pin #(.W(REG_W)) u_pin (
    .clk(clk), .rst(rst), .status_i(status_q), .mask_i(mask_q), .irq_n_o(irq_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(STATUS_ADDR)) bus_rdata = status_q;
    if (bus_addr == ADDR_W'(MASK_ADDR))   bus_rdata = mask_q;
    for (int i = 0; i < IP_BYTES; i++)
      if (bus_addr == ADDR_W'(UIP_ADDR + i))
        bus_rdata = uip_q[IP_W-1-REG_W*i -: REG_W];
    for (int i = 0; i < PORT_BYTES; i++)
      if (bus_addr == ADDR_W'(UPORT_ADDR + i))
        bus_rdata = uport_q[PORT_W-1-REG_W*i -: REG_W];
  end
endmodule

// File: rtl/nic_irq_checker.sv
module nic_irq_checker
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NSOCK  = 4,
  parameter int SIR_W  = 8,
  parameter int IP_W   = 32,
  parameter int PORT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_we,
  input logic [REG_W-1:0]       bus_wdata,
  input logic [REG_W-1:0]       bus_rdata,
  input logic                   ev_addr_clash,
  input logic                   ev_unreach,
  input logic [IP_W-1:0]        uip_in,
  input logic [PORT_W-1:0]      uport_in,
  input logic [NSOCK*SIR_W-1:0] sock_ir_in,
  input logic                   irq_n,
  input logic [REG_W-1:0]       status_q,
  input logic [REG_W-1:0]       mask_q,
  input logic [IP_W-1:0]        uip_q,
  input logic [PORT_W-1:0]      uport_q
);
  logic [NSOCK-1:0] sock_nz;
  logic             st_wr, mk_wr;

  for (genvar s = 0; s < NSOCK; s++) begin : g_nz
    assign sock_nz[s] = |sock_ir_in[s*SIR_W +: SIR_W];
  end
  assign st_wr = bus_we && (bus_addr == ADDR_W'(STATUS_ADDR));
  assign mk_wr = bus_we && (bus_addr == ADDR_W'(MASK_ADDR));

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_n && status_q == '0 && mask_q == '0));

  a_r2_clash_sets: assert property (@(posedge clk) disable iff (rst)
    ev_addr_clash |=> status_q[BIT_CLASH]);

  for (genvar b = BIT_PPPOE; b <= BIT_CLASH; b++) begin : g_w1c
    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
      $fell(status_q[b]) |-> $past(st_wr && bus_wdata[b]));
  end

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (ev_unreach && st_wr && bus_wdata[BIT_UNREACH]) |=> status_q[BIT_UNREACH]);

  a_r5_sock_follow: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status_q[NSOCK-1:0] == $past(sock_nz)));

  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    ev_unreach |=> (uip_q == $past(uip_in) && uport_q == $past(uport_in)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !ev_unreach |=> ($stable(uip_q) && $stable(uport_q)));

  a_r7_low_needs_enabled: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(|(status_q & mask_q)));

  a_r7_high_when_clear: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & mask_q)) |=> irq_n);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(STATUS_ADDR)) |-> !bus_rdata[BIT_RSVD]);

  a_r9_mask_holds: assert property (@(posedge clk) disable iff (rst)
    !mk_wr |=> $stable(mask_q));
endmodule

bind nic_irq_aggregator nic_irq_checker #(
  .ADDR_W(ADDR_W), .NSOCK(NSOCK), .SIR_W(SIR_W), .IP_W(IP_W), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_addr_clash(ev_addr_clash),
  .ev_unreach(ev_unreach), .uip_in(uip_in), .uport_in(uport_in),
  .sock_ir_in(sock_ir_in), .irq_n(irq_n), .status_q(status_q),
  .mask_q(mask_q), .uip_q(uip_q), .uport_q(uport_q)
);

// File: tb/nic_irq_aggregator_tb.sv
`timescale 1ns/1ps
module nic_irq_aggregator_tb;
  localparam int CLK_NS = 20;
  localparam logic [7:0] A_ST = 8'h15, A_MK = 8'h16, A_IP = 8'h17, A_PT = 8'h1B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ev_addr_clash = 1'b0, ev_unreach = 1'b0, ev_pppoe_down = 1'b0;
  logic [31:0] uip_in = '0;
  logic [15:0] uport_in = '0;
  logic [31:0] sock_ir_in = '0;
  logic        irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int         q_kind[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #(CLK_NS/2) clk = ~clk;

  nic_irq_aggregator u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_addr_clash(ev_addr_clash),
    .ev_unreach(ev_unreach), .ev_pppoe_down(ev_pppoe_down), .uip_in(uip_in),
    .uport_in(uport_in), .sock_ir_in(sock_ir_in), .irq_n(irq_n)
  );

  // monitor: pops expected items mid low phase and compares
  always begin
    int         k;
    logic [7:0] e, got;
    string      t;
    @(negedge clk);
    #(CLK_NS/4);
    while (q_kind.size() > 0) begin
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      got = (k == 0) ? bus_rdata : {7'b0, irq_n};
      checks++;
      if (got !== e) begin
        errors++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", t, got, e);
      end
    end
  end

  task automatic push(input int k, input logic [7:0] e, input string t);
    q_kind.push_back(k);
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  task automatic expect_read(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    push(0, e, t);
  endtask

  task automatic irq_now(input logic e, input string t);
    push(1, {7'b0, e}, t);
  endtask

  task automatic expect_irq(input logic e, input string t);
    @(negedge clk);
    push(1, {7'b0, e}, t);
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_addr_clash = 1'b1;
      1: ev_unreach = 1'b1;
      default: ev_pppoe_down = 1'b1;
    endcase
    @(negedge clk);
    ev_addr_clash = 1'b0; ev_unreach = 1'b0; ev_pppoe_down = 1'b0;
  endtask

  task automatic set_sock(input logic [31:0] v);
    @(negedge clk);
    sock_ir_in = v;
  endtask

  task automatic read_capture(input logic [31:0] ip, input logic [15:0] pt, input string t);
    for (int i = 0; i < 4; i++)
      expect_read(A_IP + 8'(i), ip[31-8*i -: 8], t);
    for (int i = 0; i < 2; i++)
      expect_read(A_PT + 8'(i), pt[15-8*i -: 8], t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    expect_read(A_ST, 8'h00, "R1 status after reset");
    expect_read(A_MK, 8'h00, "R1 mask after reset");
    irq_now(1'b1, "R1 irq_n after reset");
    read_capture(32'h0, 16'h0, "R1 capture after reset");

    // R2 address clash with mask closed; R7 masked source silent
    pulse(0);
    irq_now(1'b1, "R7 closed mask keeps pin high");
    expect_read(A_ST, 8'h80, "R2 clash sets bit 7");
    irq_now(1'b1, "R7 closed mask keeps pin high later");

    // R9 mask write; R7 pin one cycle after mask change
    write_reg(A_MK, 8'hFF);
    irq_now(1'b1, "R7 pin not yet low in mask-change cycle");
    expect_irq(1'b0, "R7 pin low one cycle after mask opens");
    expect_read(A_MK, 8'hFF, "R9 mask readback");

    // R3 write-one-to-clear
    write_reg(A_ST, 8'h00);
    expect_read(A_ST, 8'h80, "R3 writing zero keeps bit 7");
    write_reg(A_ST, 8'h7F);
    expect_read(A_ST, 8'h80, "R3 writing other bits keeps bit 7");
    write_reg(A_ST, 8'h80);
    irq_now(1'b0, "R7 pin still low in clear cycle");
    expect_read(A_ST, 8'h00, "R3 writing one clears bit 7");
    irq_now(1'b1, "R7 pin high one cycle after clear");

    // R4 set beats clear
    @(negedge clk);
    ev_addr_clash = 1'b1; bus_addr = A_ST; bus_we = 1'b1; bus_wdata = 8'h80;
    @(negedge clk);
    ev_addr_clash = 1'b0; bus_we = 1'b0;
    expect_read(A_ST, 8'h80, "R4 strobe wins over clear");
    write_reg(A_ST, 8'h80);
    expect_read(A_ST, 8'h00, "R4 later clear works");

    // R6 capture, then re-capture while bit 6 set, then hold
    uip_in = 32'hC0A8_0107; uport_in = 16'h1F90;
    pulse(1);
    expect_read(A_ST, 8'h40, "R2 unreachable sets bit 6");
    read_capture(32'hC0A8_0107, 16'h1F90, "R6 first capture");
    uip_in = 32'h0A00_00FE; uport_in = 16'h0035;
    pulse(1);
    read_capture(32'h0A00_00FE, 16'h0035, "R6 recapture with bit 6 set");
    uip_in = 32'hDEAD_BEEF; uport_in = 16'hAAAA;
    read_capture(32'h0A00_00FE, 16'h0035, "R6 hold without strobe");

    // R2 session-down; R8 reserved bit
    pulse(2);
    expect_read(A_ST, 8'h60, "R2 session down sets bit 5");
    write_reg(A_ST, 8'h70);
    expect_read(A_ST, 8'h00, "R8 bit 4 reads 0 after write of 1");

    // R5 socket summaries
    set_sock(32'h0005_0000);
    expect_read(A_ST, 8'h04, "R5 socket 2 busy");
    write_reg(A_ST, 8'h0F);
    expect_read(A_ST, 8'h04, "R5 host write to bits 3..0 ignored");
    set_sock(32'h0005_0001);
    expect_read(A_ST, 8'h05, "R5 sockets 2 and 0 busy");
    set_sock(32'h0000_0001);
    expect_read(A_ST, 8'h01, "R5 socket 2 cleared");
    set_sock(32'h0);
    expect_read(A_ST, 8'h00, "R5 all sockets idle");

    // R7 single-bit mask: only socket 0 may drive the pin
    write_reg(A_MK, 8'h01);
    pulse(0);
    expect_irq(1'b1, "R7 masked clash leaves pin high");
    expect_read(A_ST, 8'h80, "R7 clash visible while masked");
    set_sock(32'h0000_0080);
    expect_read(A_ST, 8'h81, "R5 socket 0 busy with clash");
    irq_now(1'b1, "R7 pin high in status-change cycle");
    expect_irq(1'b0, "R7 enabled socket 0 pulls pin low");
    set_sock(32'h0);
    expect_read(A_ST, 8'h80, "R5 socket 0 back to idle");
    irq_now(1'b0, "R7 pin still low for one cycle");
    expect_irq(1'b1, "R7 pin released after enabled bit clears");
    write_reg(A_ST, 8'h80);
    expect_read(A_ST, 8'h00, "R3 final clear");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule